// File: doc/BRIEF.md
# Register Scoreboard Issue Checker

This block holds one reservation flag per architectural register and decides, each cycle, whether an instruction with one destination and two source registers may dispatch. A set flag means a result for that register is still in flight. A clear flag means the register holds usable data. The decision is combinational. When the instruction is granted, its destination is reserved from the next cycle on. A writeback port frees a register in any order, and the freed register counts as free for a request in the same cycle.

A stalled request leaves the flags untouched. The front end holds the request on the inputs until it is granted. A two-bit reason code tells which hazard blocked it. A parameter can make register 0 a constant register that is never reserved.

Top module: `sb_issue_check`

## Requirements
- R1: After reset every reservation flag is clear, so any request is granted.
- R2: A valid request with none of its three registers reserved is granted in the same cycle: `grant`=1, `stall`=0, `stall_why`=0 (none).
- R3: A valid request with either source reserved stalls with `stall_why`=1 (read-after-write).
- R4: A valid request with both sources free and the destination reserved stalls with `stall_why`=2 (write-after-write).
- R5: When both hazards apply, the reason reported is read-after-write (code 1).
- R6: A grant reserves the destination from the next cycle on.
- R7: A writeback clears the flag of its register, whatever the order in which the registers were reserved.
- R8: A writeback in the same cycle as a request is seen by that request's check, and the freed register counts as free.
- R9: With `ZERO_REG_FREE`=1, register 0 is never reserved, even when it is granted as a destination.
- R10: With `req_valid`=0, `grant` and `stall` are 0 and `stall_why` is 0.
- R11: A stalled request changes no flag. Its destination stays free if it was free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A dispatch request is present |
| req_dst | input | REG_IDX_W | Destination register index |
| req_src_a | input | REG_IDX_W | First source register index |
| req_src_b | input | REG_IDX_W | Second source register index |
| wb_valid | input | 1 | A writeback completes this cycle |
| wb_idx | input | REG_IDX_W | Register written back |
| grant | output | 1 | Request may dispatch this cycle |
| stall | output | 1 | Request must wait |
| stall_why | output | 2 | 0 none, 1 read-after-write, 2 write-after-write |

## Verification
The first test holds registers 3 and 5 reserved and tries every destination and source triple. This separates a hazard on a source from one on the destination, and shows which reason wins when both apply. After each granted triple, a writeback frees the destination again, so the reserved set stays the same for the whole run. A long pseudorandom run then mixes requests with writebacks. Some of these writebacks hit a requested register in the same cycle, which tells a correct same-cycle bypass from a registered one. Directed probes cover the reset state, writebacks in a different order from the grants, a stalled request, and register 0 used as a destination.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        WHY_NONE = 2'd0,
        WHY_RAW  = 2'd1,
        WHY_WAW  = 2'd2
    } stall_why_e;
endpackage

// File: rtl/sb_resv_array.sv
module sb_resv_array #(
    parameter int IDX_W     = 4,
    parameter bit ZERO_FREE = 1'b1,
    localparam int NREGS    = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [NREGS-1:0] busy_view
);
    typedef struct packed {
        logic [NREGS-1:0] resv;
    } state_t;

    state_t st_d, st_q;

    // Per-register flag after the same-cycle writeback is applied.
    for (genvar gi = 0; gi < NREGS; gi++) begin : g_bit
        if (ZERO_FREE && gi == 0) begin : g_const
            assign busy_view[gi] = 1'b0;
        end else begin : g_live
            assign busy_view[gi] = st_q.resv[gi] &
                                   ~(wb_valid && wb_idx == IDX_W'(gi));
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.resv = busy_view;
        if (set_en) st_d.resv[set_idx] = 1'b1;
        if (ZERO_FREE) st_d.resv[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A grant to a nonzero destination reserves it on the next cycle.
    p_set_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && (set_idx != '0 || !ZERO_FREE)) |=> st_q.resv[$past(set_idx)]);

    // A writeback that is not re-reserved in the same cycle leaves the flag clear.
    p_wb_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(set_en && set_idx == wb_idx)) |=> !st_q.resv[$past(wb_idx)]);

    // Register 0 is never reserved.
    p_zero_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ZERO_FREE |-> !st_q.resv[0]);

    // With no grant and no writeback, the flags hold.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !wb_valid) |=> st_q.resv == $past(st_q.resv));
endmodule

// File: rtl/sb_hazard_eval.sv
module sb_hazard_eval
    import sb_pkg::*;
#(
    parameter int IDX_W  = 4,
    localparam int NREGS = 1 << IDX_W
) (
    input  logic [NREGS-1:0] busy_view,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_dst,
    input  logic [IDX_W-1:0] req_src_a,
    input  logic [IDX_W-1:0] req_src_b,
    output logic             grant,
    output logic             stall,
    output stall_why_e       why
);
    logic raw_hit, waw_hit;

    always_comb begin
        raw_hit = busy_view[req_src_a] | busy_view[req_src_b];
        waw_hit = busy_view[req_dst];
        grant   = req_valid & ~raw_hit & ~waw_hit;
        stall   = req_valid & (raw_hit | waw_hit);
        if (!req_valid)   why = WHY_NONE;
        else if (raw_hit) why = WHY_RAW;
        else if (waw_hit) why = WHY_WAW;
        else              why = WHY_NONE;
    end
endmodule

// File: rtl/sb_issue_check.sv
module sb_issue_check
    import sb_pkg::*;
#(
    parameter int REG_IDX_W     = 4,
    parameter bit ZERO_REG_FREE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [REG_IDX_W-1:0] req_dst,
    input  logic [REG_IDX_W-1:0] req_src_a,
    input  logic [REG_IDX_W-1:0] req_src_b,
    input  logic                 wb_valid,
    input  logic [REG_IDX_W-1:0] wb_idx,
    output logic                 grant,
    output logic                 stall,
    output logic [1:0]           stall_why
);
    localparam int NREGS = 1 << REG_IDX_W;

    logic [NREGS-1:0] busy_view;
    stall_why_e       why_e;

    sb_resv_array #(
        .IDX_W     (REG_IDX_W),
        .ZERO_FREE (ZERO_REG_FREE)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_valid  (wb_valid),
        .wb_idx    (wb_idx),
        .set_en    (grant),
        .set_idx   (req_dst),
        .busy_view (busy_view)
    );

    sb_hazard_eval #(
        .IDX_W (REG_IDX_W)
    ) u_eval (
        .busy_view (busy_view),
        .req_valid (req_valid),
        .req_dst   (req_dst),
        .req_src_a (req_src_a),
        .req_src_b (req_src_b),
        .grant     (grant),
        .stall     (stall),
        .why       (why_e)
    );

    assign stall_why = why_e;

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && stall));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !stall && stall_why == 2'd0));

    p_stall_reason_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (stall_why == 2'd1 || stall_why == 2'd2));

    p_grant_reason_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> stall_why == 2'd0);
endmodule

// File: tb/sim_sb_issue_check.sv
module sim_sb_issue_check;
    localparam int CLK_PERIOD = 10;
    localparam int W = 3;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [W-1:0] req_dst = '0, req_src_a = '0, req_src_b = '0;
    logic         wb_valid = 1'b0;
    logic [W-1:0] wb_idx = '0;
    logic         grant, stall;
    logic [1:0]   stall_why;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_q = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_issue_check #(.REG_IDX_W(W), .ZERO_REG_FREE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
        .req_src_a(req_src_a), .req_src_b(req_src_b), .wb_valid(wb_valid),
        .wb_idx(wb_idx), .grant(grant), .stall(stall), .stall_why(stall_why)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drives one cycle, checks the combinational outputs, then updates the model.
    task automatic step(input logic v, input logic [W-1:0] d, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic wv, input logic [W-1:0] wi,
                        input string tag);
        logic [N-1:0] eff;
        logic raw, waw, eg, es;
        logic [1:0] ew;
        string t;
        @(negedge clk);
        req_valid = v; req_dst = d; req_src_a = a; req_src_b = b;
        wb_valid = wv; wb_idx = wi;
        #1;
        eff = exp_q;
        if (wv) eff[wi] = 1'b0;
        eff[0] = 1'b0;
        raw = eff[a] | eff[b];
        waw = eff[d];
        eg = v && !raw && !waw;
        es = v && (raw || waw);
        ew = !v ? 2'd0 : raw ? 2'd1 : waw ? 2'd2 : 2'd0;
        t = tag;
        if (t == "") t = !v ? "R10" : (raw && waw) ? "R5" : raw ? "R3" : waw ? "R4" : "R2";
        checks++;
        if (grant !== eg || stall !== es || stall_why !== ew) begin
            errors++;
            $display("FAIL %s: got grant=%b stall=%b why=%0d, expected grant=%b stall=%b why=%0d",
                     t, grant, stall, stall_why, eg, es, ew);
        end
        @(posedge clk);
        exp_q = eff;
        if (eg) exp_q[d] = 1'b1;
        exp_q[0] = 1'b0;
    endtask

    // Reads one register's flag through a request with that register as both sources.
    task automatic probe(input logic [W-1:0] r, input logic exp_busy, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_dst = '0; req_src_a = r; req_src_b = r; wb_valid = 1'b0;
        #1;
        checks++;
        if (stall !== exp_busy) begin
            errors++;
            $display("FAIL %s: reg %0d busy got %b, expected %b", tag, r, stall, exp_busy);
        end
        @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, every register free
        for (int r = 0; r < N; r++) probe(W'(r), 1'b0, "R1");

        // R10: idle request
        step(1'b0, 3'd2, 3'd2, 3'd2, 1'b0, 3'd0, "R10");

        // R6: grant reserves destination; R11: stalled request changes nothing
        step(1'b1, 3'd4, 3'd1, 3'd2, 1'b0, 3'd0, "R2");
        probe(3'd4, 1'b1, "R6");
        step(1'b1, 3'd6, 3'd4, 3'd1, 1'b0, 3'd0, "R3");
        probe(3'd6, 1'b0, "R11");

        // R7: out-of-order completion
        step(1'b1, 3'd6, 3'd1, 3'd1, 1'b0, 3'd0, "R2");
        step(1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 3'd6, "R7");
        probe(3'd6, 1'b0, "R7");
        probe(3'd4, 1'b1, "R7");

        // R8: same-cycle writeback bypass into the check
        step(1'b1, 3'd4, 3'd4, 3'd1, 1'b1, 3'd4, "R8");
        probe(3'd4, 1'b1, "R8");
        step(1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 3'd4, "R7");

        // R9: register 0 as destination never becomes reserved
        step(1'b1, 3'd0, 3'd1, 3'd2, 1'b0, 3'd0, "R9");
        probe(3'd0, 1'b0, "R9");
        step(1'b1, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, "R9");

        // Exhaustive triple sweep with registers 3 and 5 reserved
        step(1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 3'd0, "R6");
        step(1'b1, 3'd5, 3'd0, 3'd0, 1'b0, 3'd0, "R6");
        for (int d = 0; d < N; d++)
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++) begin
                    logic undo;
                    undo = (d != 0) && (d != 3) && (d != 5) && (a != 3) && (a != 5)
                           && (b != 3) && (b != 5);
                    step(1'b1, W'(d), W'(a), W'(b), 1'b0, 3'd0, "");
                    if (undo) step(1'b0, 3'd0, 3'd0, 3'd0, 1'b1, W'(d), "R7");
                end
        step(1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 3'd3, "R7");
        step(1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 3'd5, "R7");

        // Pseudorandom mix of requests and writebacks, including bypass hits
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[1], lf[4:2], lf[7:5], lf[10:8], lf[11] & lf[12],
                 lf[15:13], (lf[11] && (lf[15:13] == lf[7:5] || lf[15:13] == lf[4:2])) ? "R8" : "");
        end

        finish_run();
    end
endmodule